// File: doc/BRIEF.md
# Microcontroller GPIO Port Pair

This unit gives a small microcontroller two ports on its register bus. One is an 8-bit bidirectional port and the other is a 4-bit input-only port. The CPU writes an output latch for the bidirectional port. It reads the live pad levels of either port in the same cycle as the read strobe; no register sits in the read path. For every pad bit the unit drives an output-enable, an output value and a pull-up enable.

The upper four bits of the bidirectional port are always open-drain with pull-ups. A latch 0 pulls the pin low and a latch 1 releases it. For the lower four bits, build parameters choose open-drain or push-pull drive, and whether pull-ups are fitted.

Bit-set, bit-clear and bit-complement commands take the current pin levels, change one bit and store the whole byte in the latch. As a result, a released open-drain pin that is held low from outside is written back as 0.

A per-bit build mask selects which bidirectional pins can raise a one-cycle wake-up request. The request fires when the pin, after synchronisation, goes from high to low.

Top module: `gpio_port_pair`

## Requirements
- R1: While reset is asserted, and after it, the output latch holds all ones. Every open-drain bit therefore has its output-enable low.
- R2: The latch changes only on a clock edge where `bus_wr` is high and `bus_addr` equals BIDIR_ADDR (0x12). The new value is visible on the pad outputs after that edge. A write to any other address leaves the latch unchanged.
- R3: Bits 7..4 are open-drain. `pa_oe[i]` is the inverse of latch bit i, `pa_out[i]` is 0 and `pa_pu[i]` is 1.
- R4: Bits 3..0 follow LO_PUSHPULL. When it is 1, `pa_oe` is 1 and `pa_out` is the latch bit. When it is 0, these bits are open-drain as in R3. `pa_pu[3:0]` equals LO_PULLUP on every bit.
- R5: `pb_pu` is all ones. A write to INPUT_ADDR (0x14) has no effect on any output.
- R6: `bus_rdata` is combinational. With `bus_rd` high, address 0x12 returns `pa_pad_in` and address 0x14 returns `{4'b0, pb_pad_in}`. Any other address, or `bus_rd` low, returns 0.
- R7: A write to 0x12 carries a command in `bus_op`: 0 stores `bus_wdata` in the latch. Commands 1 (set), 2 (clear) and 3 (complement) act on bit `bus_wdata[2:0]` of the current `pa_pad_in` value. The result is stored in the latch.
- R8: `wake_req` is high for exactly one cycle, after the third clock edge following a 1-to-0 change on a `pa_pad_in` bit that is set in WAKE_MASK. A falling edge on a bit that is clear in WAKE_MASK never raises it.
- R9: `wake_req` is low during reset. No pulse follows reset while the pads stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_op | input | 2 | Write command: 0 byte, 1 set, 2 clear, 3 complement |
| bus_wdata | input | 8 | Write data, or bit index in [2:0] |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| pa_pad_in | input | 8 | Bidirectional port pad levels |
| pa_oe | output | 8 | Bidirectional port output-enable |
| pa_out | output | 8 | Bidirectional port output value |
| pa_pu | output | 8 | Bidirectional port pull-up enable |
| pb_pad_in | input | 4 | Input port pad levels |
| pb_pu | output | 4 | Input port pull-up enable |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The bench tests several corner cases, each chosen to expose a specific fault:

- **Bit commands on a pin held low.** A released open-drain pin is held low from outside, then a bit command targets a different bit. If the design modified the latch instead of the pins, the low pin would wrongly stay released.
- **Writes to the input-only address and to a neighbouring address.** A mis-decoded address would disturb the latch.
- **Reads issued in the same cycle as a pad change.** A registered read path would return the previous level.
- **Falling edges on masked and unmasked bits, including back-to-back toggles.** These reveal a missing mask, a level-triggered request, or wrong synchroniser depth, which would show up as a pulse that is early, late or too long.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    OP_BYTE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_CPL  = 2'd3
  } port_op_e;
endpackage

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hit,
  input  gpio_pkg::port_op_e   op,
  input  logic [W-1:0]         wdata,
  input  logic [W-1:0]         pins,
  output logic [W-1:0]         latch_q
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  logic [IW-1:0] idx;
  logic [W-1:0]  sel;
  logic [W-1:0]  next_val;

  assign idx = wdata[IW-1:0];
  assign sel = W'(1) << idx;

  always_comb begin
    unique case (op)
      gpio_pkg::OP_SET: next_val = pins | sel;
      gpio_pkg::OP_CLR: next_val = pins & ~sel;
      gpio_pkg::OP_CPL: next_val = pins ^ sel;
      default:          next_val = wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      latch_q <= '1;
    else if (hit) latch_q <= next_val;
  end

  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(latch_q));
  assert_reset_ones_R1: assert property (@(posedge clk)
    $past(rst) |-> (latch_q == '1));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W           = 8,
  parameter int LO_W        = 4,
  parameter bit LO_PUSHPULL = 1'b1,
  parameter bit LO_PULLUP   = 1'b0
) (
  input  logic [W-1:0] latch_q,
  output logic [W-1:0] oe,
  output logic [W-1:0] out,
  output logic [W-1:0] pu
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < LO_W && LO_PUSHPULL) begin : g_pp
      assign oe[i]  = 1'b1;
      assign out[i] = latch_q[i];
    end else begin : g_od
      assign oe[i]  = ~latch_q[i];
      assign out[i] = 1'b0;
    end
    if (i < LO_W) begin : g_lopu
      assign pu[i] = LO_PULLUP;
    end else begin : g_hipu
      assign pu[i] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect #(
  parameter int           W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad,
  output logic         wake
);
  logic [W-1:0] s1, s2, s3, fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= '1;
      s2     <= '1;
      s3     <= '1;
      fall_q <= '0;
    end else begin
      s1     <= pad;
      s2     <= s1;
      s3     <= s2;
      fall_q <= MASK & s3 & ~s2;
    end
  end

  assign wake = |fall_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_wake_single_R8: assert property (@(posedge clk) disable iff (rst)
      fall_q[i] |=> !fall_q[i]);
  end
  assert_wake_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> !wake);
endmodule

// File: rtl/gpio_port_pair.sv
module gpio_port_pair #(
  parameter int          AW          = 8,
  parameter int          DW          = 8,
  parameter int          PA_W        = 8,
  parameter int          PB_W        = 4,
  parameter int          LO_W        = 4,
  parameter logic [AW-1:0] BIDIR_ADDR = 8'h12,
  parameter logic [AW-1:0] INPUT_ADDR = 8'h14,
  parameter bit          LO_PUSHPULL = 1'b1,
  parameter bit          LO_PULLUP   = 1'b0,
  parameter logic [PA_W-1:0] WAKE_MASK = 8'b1011_0101
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [1:0]      bus_op,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  input  logic [PA_W-1:0] pa_pad_in,
  output logic [PA_W-1:0] pa_oe,
  output logic [PA_W-1:0] pa_out,
  output logic [PA_W-1:0] pa_pu,
  input  logic [PB_W-1:0] pb_pad_in,
  output logic [PB_W-1:0] pb_pu,
  output logic            wake_req
);
  logic              pa_hit;
  logic [PA_W-1:0]   latch_q;
  gpio_pkg::port_op_e op;

  assign pa_hit = bus_wr && (bus_addr == BIDIR_ADDR);
  assign op     = gpio_pkg::port_op_e'(bus_op);
  assign pb_pu  = '1;

  gpio_out_latch #(.W(PA_W)) u_latch (
    .clk(clk), .rst(rst), .hit(pa_hit), .op(op),
    .wdata(bus_wdata[PA_W-1:0]), .pins(pa_pad_in), .latch_q(latch_q)
  );

  gpio_pad_drive #(.W(PA_W), .LO_W(LO_W), .LO_PUSHPULL(LO_PUSHPULL),
                   .LO_PULLUP(LO_PULLUP)) u_drive (
    .latch_q(latch_q), .oe(pa_oe), .out(pa_out), .pu(pa_pu)
  );

  gpio_wake_detect #(.W(PA_W), .MASK(WAKE_MASK)) u_wake (
    .clk(clk), .rst(rst), .pad(pa_pad_in), .wake(wake_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == BIDIR_ADDR)      bus_rdata = DW'(pa_pad_in);
      else if (bus_addr == INPUT_ADDR) bus_rdata = DW'(pb_pad_in);
    end
  end

  assert_read_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |-> (bus_rdata == '0));
  assert_od_release_R3: assert property (@(posedge clk) disable iff (rst)
    (pa_hit && op == gpio_pkg::OP_BYTE && bus_wdata[PA_W-1]) |=> !pa_oe[PA_W-1]);
  assert_input_write_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == INPUT_ADDR) |=> ($stable(pa_oe) && $stable(pa_out)));
endmodule

// File: tb/tb_gpio_port_pair.sv
module tb_gpio_port_pair;
  localparam logic [7:0] MASK = 8'b1011_0101;
  localparam bit PP = 1'b1;
  localparam bit PU = 1'b0;

  logic       clk = 0, rst = 1;
  logic [7:0] bus_addr = 0, bus_wdata = 0, pa_pad_in = 8'hFF;
  logic       bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_op = 0;
  logic [3:0] pb_pad_in = 4'hF;
  logic [7:0] bus_rdata, pa_oe, pa_out, pa_pu;
  logic [3:0] pb_pu;
  logic       wake_req;

  int vecs = 0, errs = 0;
  logic [7:0] m_lat;
  logic [7:0] hist [4];
  logic       m_wake;

  gpio_port_pair dut (.*);

  always #2.5 clk = ~clk;

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_lat = 8'hFF; m_wake = 0;
      for (int k = 0; k < 4; k++) hist[k] = 8'hFF;
    end else begin
      if (bus_wr && bus_addr == 8'h12) begin
        case (bus_op)
          2'd1: m_lat = pa_pad_in | (8'd1 << bus_wdata[2:0]);
          2'd2: m_lat = pa_pad_in & ~(8'd1 << bus_wdata[2:0]);
          2'd3: m_lat = pa_pad_in ^ (8'd1 << bus_wdata[2:0]);
          default: m_lat = bus_wdata;
        endcase
      end
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = pa_pad_in;
      m_wake = |(MASK & hist[3] & ~hist[2]);
    end
  end

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (m_lat !== 8'bx) begin
      logic [7:0] eoe, eout;
      logic [7:0] erd;
      for (int i = 0; i < 8; i++) begin
        if (i < 4 && PP) begin eoe[i] = 1; eout[i] = m_lat[i]; end
        else begin eoe[i] = ~m_lat[i]; eout[i] = 0; end
      end
      erd = !bus_rd ? 8'h00 : bus_addr == 8'h12 ? pa_pad_in :
            bus_addr == 8'h14 ? {4'h0, pb_pad_in} : 8'h00;
      cmp("R1/R2/R3/R4 oe", pa_oe, eoe);
      cmp("R2/R3/R4 out", pa_out, eout);
      cmp("R3/R4 pu", pa_pu, {4'hF, {4{PU}}});
      cmp("R5 pb_pu", pb_pu, 4'hF);
      cmp("R6 rdata", bus_rdata, erd);
      cmp("R8/R9 wake", wake_req, m_wake);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [1:0] op, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_op = op; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                                    // R1, R9 reset state
    repeat (4) @(negedge clk);
    wr(8'h12, 2'd0, 8'h5A);                     // R2 R3 R4 byte write
    wr(8'h13, 2'd0, 8'h00);                     // R2 other address
    wr(8'h14, 2'd0, 8'h00);                     // R5 input port write
    pb_pad_in = 4'h9; rd(8'h14);                // R6
    pa_pad_in = 8'hC3; rd(8'h12);               // R6
    @(negedge clk); bus_addr = 8'h12; bus_rd = 1; pa_pad_in = 8'h3C; // R6 same-cycle
    @(negedge clk); bus_rd = 0; rd(8'h15);
    pa_pad_in = 8'hFF;
    wr(8'h12, 2'd0, 8'hFF);
    pa_pad_in = 8'h7F;                          // bit 7 held low externally
    wr(8'h12, 2'd1, 8'd0);                      // R7 set bit 0 from pins
    wr(8'h12, 2'd2, 8'd2);                      // R7 clear bit 2
    wr(8'h12, 2'd3, 8'd6);                      // R7 complement bit 6
    pa_pad_in = 8'hFF; repeat (5) @(negedge clk);
    pa_pad_in = 8'hFE; repeat (6) @(negedge clk);  // R8 masked bit 0 falls
    pa_pad_in = 8'hFF; repeat (4) @(negedge clk);
    pa_pad_in = 8'hFD; repeat (6) @(negedge clk);  // R8 unmasked bit 1 falls
    pa_pad_in = 8'hFF; repeat (4) @(negedge clk);
    pa_pad_in = 8'h7F; @(negedge clk); pa_pad_in = 8'hFF; @(negedge clk);
    pa_pad_in = 8'h7F; repeat (6) @(negedge clk);  // R8 back-to-back toggles
    pa_pad_in = 8'h00; repeat (6) @(negedge clk);
    for (int n = 0; n < 40; n++) begin
      pa_pad_in = 8'(n * 37 + 11); pb_pad_in = 4'(n);
      if (n % 3 == 0) wr(8'h12, 2'(n), 8'(n * 13));
      else rd((n % 2) ? 8'h12 : 8'h14);
    end
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;  // R1 R9 re-reset
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule